// File: doc/BRIEF.md
# Triggered Loop Index Generator

This block is one node of a dataflow fabric. It produces a loop index for nodes further down the graph. The index leaves the node as a 16-bit data word paired with a one-bit execute-enable (EE) strobe. Each EE pulse marks a new index value, so every consumer fires once per iteration. When the loop finishes, the node raises a one-cycle exit strobe on a second output. That output carries its own data word: the value that ended the loop.

The node has two pacing modes. In stepped mode, a loop-start pulse loads the first index and each step pulse from another node adds the increment. In self-paced mode, the step pulse is ignored and the node advances on its own, with a configurable number of idle cycles between iterations. The first value, the bound and the increment can each come from a constant held in the node or from an input port. An input port captures its value whenever its own EE strobe is high.

Top module: `loop_index_node`

## Requirements
- R1: While reset is held, and on the first cycle after it, idx_ee and exit_ee are 0, and idx_data and exit_data are 0.
- R2: A loop_start pulse sampled at a clock edge loads the first value. If that value is below the bound, idx_data shows it with idx_ee high in the following cycle.
- R3: In stepped mode (cfg_mode = 0), a loop_next pulse while the loop is active produces idx_data = previous index + increment, with a one-cycle idx_ee pulse in the following cycle.
- R4: When a newly computed index is at or above the bound, or overflows 16 bits, it is not emitted. Instead exit_ee pulses for one cycle, and exit_data holds the low 16 bits of the computed value; idx_ee stays low in that cycle.
- R5: loop_next pulses arriving before any start, or after the exit pulse, produce neither idx_ee nor exit_ee. No pulses appear until the next loop_start.
- R6: For each operand whose cfg_*_var bit is 1, the operand value is the most recent data captured with that port's EE strobe. When the strobe is high in the same cycle as its use, the new data is used. With the bit at 0, the matching cfg_*_k constant is used.
- R7: In self-paced mode (cfg_mode = 1), exactly cfg_gap idle cycles separate consecutive idx_ee pulses, counted from the start pulse onward, and loop_next has no effect.
- R8: In self-paced mode with cfg_gap = 0, a new index is emitted on every clock cycle until exit.
- R9: A loop_start pulse while a loop is active restarts the loop from the first value, and it takes priority over a step in the same cycle.
- R10: idx_data keeps its value in every cycle in which idx_ee is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 stepped, 1 self-paced |
| cfg_gap | input | 8 | Idle cycles between iterations in self-paced mode |
| cfg_start_var | input | 1 | First value taken from port when 1 |
| cfg_end_var | input | 1 | Bound taken from port when 1 |
| cfg_incr_var | input | 1 | Increment taken from port when 1 |
| cfg_start_k | input | 16 | Constant first value |
| cfg_end_k | input | 16 | Constant bound |
| cfg_incr_k | input | 16 | Constant increment |
| loop_start | input | 1 | Loop-start EE pulse |
| loop_next | input | 1 | Step EE pulse (stepped mode) |
| start_in_data | input | 16 | Variable first value |
| start_in_ee | input | 1 | Strobe for start_in_data |
| end_in_data | input | 16 | Variable bound |
| end_in_ee | input | 1 | Strobe for end_in_data |
| incr_in_data | input | 16 | Variable increment |
| incr_in_ee | input | 1 | Strobe for incr_in_data |
| idx_data | output | 16 | Current loop index |
| idx_ee | output | 1 | One-cycle pulse per new index |
| exit_data | output | 16 | Value that ended the loop |
| exit_ee | output | 1 | One-cycle loop-exit pulse |

The EE strobes act as valid signals with no ready. There is no back-pressure: a consumer must accept every pulse in the cycle it appears. Configuration is changed only together with a loop_start.

## Verification
The bench targets several boundary cases, each of which a faulty design would get visibly wrong:
- A first value already at the bound must produce an exit at once. A design that tests only after stepping would emit one index too many.
- An increment that carries out of 16 bits must exit. A wrapping comparison would loop forever.
- Self-paced gaps of 0 and 2 must produce the exact pulse spacing. An off-by-one in the idle counter shifts every pulse.
- A restart during a running loop, and step pulses before start or after exit, must behave as specified. Getting these wrong produces stray or missing pulses.
- A variable operand whose strobe coincides with its use must supply the new value. A design that took the stale value would load the wrong index.

// File: rtl/lidx_pkg.sv
package lidx_pkg;
  typedef enum logic {
    PACE_STEPPED = 1'b0,
    PACE_SELF    = 1'b1
  } pace_mode_e;

  localparam int unsigned N_OPERANDS = 3;
  localparam int unsigned OPR_FIRST  = 0;
  localparam int unsigned OPR_BOUND  = 1;
  localparam int unsigned OPR_STEP   = 2;
endpackage

// File: rtl/lidx_operand.sv
module lidx_operand #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         use_port,
  input  logic [W-1:0] const_val,
  input  logic [W-1:0] port_data,
  input  logic         port_ee,
  output logic [W-1:0] value
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       held_q <= '0;
    else if (port_ee) held_q <= port_data;
  end

  always_comb begin
    if (!use_port)    value = const_val;
    else if (port_ee) value = port_data;
    else              value = held_q;
  end
endmodule

// File: rtl/lidx_pacer.sv
module lidx_pacer #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [GAP_W-1:0] gap,
  output logic             tick
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (reload)       cnt_q <= gap;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/lidx_core.sv
module lidx_core
  import lidx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pace_mode_e   mode,
  input  logic         start_ee,
  input  logic         next_ee,
  input  logic         tick,
  input  logic [W-1:0] first_v,
  input  logic [W-1:0] bound_v,
  input  logic [W-1:0] step_v,
  output logic         advance,
  output logic         running,
  output logic [W-1:0] idx_data,
  output logic         idx_ee,
  output logic [W-1:0] exit_data,
  output logic         exit_ee
);
  logic         run_q;
  logic [W-1:0] idx_q;
  logic         idx_ee_q;
  logic [W-1:0] exit_q;
  logic         exit_ee_q;
  logic         step_go;
  logic [W:0]   cand;
  logic         done;

  assign step_go = run_q && !start_ee &&
                   ((mode == PACE_SELF) ? tick : next_ee);
  assign advance = start_ee || step_go;

  always_comb begin
    if (start_ee) cand = {1'b0, first_v};
    else          cand = {1'b0, idx_q} + {1'b0, step_v};
    done = cand[W] || (cand[W-1:0] >= bound_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      idx_q     <= '0;
      idx_ee_q  <= 1'b0;
      exit_q    <= '0;
      exit_ee_q <= 1'b0;
    end else begin
      idx_ee_q  <= 1'b0;
      exit_ee_q <= 1'b0;
      if (advance) begin
        if (done) begin
          run_q     <= 1'b0;
          exit_ee_q <= 1'b1;
          exit_q    <= cand[W-1:0];
        end else begin
          run_q    <= 1'b1;
          idx_ee_q <= 1'b1;
          idx_q    <= cand[W-1:0];
        end
      end
    end
  end

  assign running   = run_q;
  assign idx_data  = idx_q;
  assign idx_ee    = idx_ee_q;
  assign exit_data = exit_q;
  assign exit_ee   = exit_ee_q;
endmodule

// File: rtl/loop_index_node.sv
module loop_index_node
  import lidx_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_start_var,
  input  logic             cfg_end_var,
  input  logic             cfg_incr_var,
  input  logic [W-1:0]     cfg_start_k,
  input  logic [W-1:0]     cfg_end_k,
  input  logic [W-1:0]     cfg_incr_k,
  input  logic             loop_start,
  input  logic             loop_next,
  input  logic [W-1:0]     start_in_data,
  input  logic             start_in_ee,
  input  logic [W-1:0]     end_in_data,
  input  logic             end_in_ee,
  input  logic [W-1:0]     incr_in_data,
  input  logic             incr_in_ee,
  output logic [W-1:0]     idx_data,
  output logic             idx_ee,
  output logic [W-1:0]     exit_data,
  output logic             exit_ee
);
  logic [N_OPERANDS-1:0]          opr_sel;
  logic [N_OPERANDS-1:0][W-1:0]   opr_k;
  logic [N_OPERANDS-1:0][W-1:0]   opr_pd;
  logic [N_OPERANDS-1:0]          opr_pe;
  logic [N_OPERANDS-1:0][W-1:0]   opr_val;
  logic                           pace_tick;
  logic                           core_adv;
  logic                           core_run;
  pace_mode_e                     mode;

  assign mode = pace_mode_e'(cfg_mode);

  assign opr_sel[OPR_FIRST] = cfg_start_var;
  assign opr_sel[OPR_BOUND] = cfg_end_var;
  assign opr_sel[OPR_STEP]  = cfg_incr_var;
  assign opr_k[OPR_FIRST]   = cfg_start_k;
  assign opr_k[OPR_BOUND]   = cfg_end_k;
  assign opr_k[OPR_STEP]    = cfg_incr_k;
  assign opr_pd[OPR_FIRST]  = start_in_data;
  assign opr_pd[OPR_BOUND]  = end_in_data;
  assign opr_pd[OPR_STEP]   = incr_in_data;
  assign opr_pe[OPR_FIRST]  = start_in_ee;
  assign opr_pe[OPR_BOUND]  = end_in_ee;
  assign opr_pe[OPR_STEP]   = incr_in_ee;

  for (genvar g = 0; g < N_OPERANDS; g++) begin : g_opr
    lidx_operand #(.W(W)) u_opr (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_port (opr_sel[g]),
      .const_val(opr_k[g]),
      .port_data(opr_pd[g]),
      .port_ee  (opr_pe[g]),
      .value    (opr_val[g])
    );
  end

  lidx_pacer #(.GAP_W(GAP_W)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .reload(core_adv),
    .gap   (cfg_gap),
    .tick  (pace_tick)
  );

  lidx_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .start_ee (loop_start),
    .next_ee  (loop_next),
    .tick     (pace_tick),
    .first_v  (opr_val[OPR_FIRST]),
    .bound_v  (opr_val[OPR_BOUND]),
    .step_v   (opr_val[OPR_STEP]),
    .advance  (core_adv),
    .running  (core_run),
    .idx_data (idx_data),
    .idx_ee   (idx_ee),
    .exit_data(exit_data),
    .exit_ee  (exit_ee)
  );
endmodule

// File: rtl/lidx_checker.sv
module lidx_checker #(
  parameter int unsigned W     = 16,
  parameter int unsigned GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_mode,
  input logic [GAP_W-1:0] cfg_gap,
  input logic             loop_start,
  input logic             run,
  input logic [W-1:0]     idx_data,
  input logic             idx_ee,
  input logic             exit_ee
);
  // R4: exit and index pulses never coincide
  a_r4_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_ee && exit_ee));

  // R4: once exit fires, the loop is no longer active
  a_r4_exit_stops: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ee |-> !run);

  // R5: an idle node without start emits nothing
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !loop_start) |=> (!idx_ee && !exit_ee));

  // R2: every start is answered by an index or an exit
  a_r2_start_answered: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start |=> (idx_ee || exit_ee));

  // R8: zero gap in self-paced mode advances every cycle
  a_r8_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg_mode && (cfg_gap == '0) && !loop_start) |=> (idx_ee || exit_ee));

  // R10: index data holds between pulses
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ee |-> $stable(idx_data));
endmodule

bind loop_index_node lidx_checker #(.W(W), .GAP_W(GAP_W)) u_lidx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .cfg_gap   (cfg_gap),
  .loop_start(loop_start),
  .run       (core_run),
  .idx_data  (idx_data),
  .idx_ee    (idx_ee),
  .exit_ee   (exit_ee)
);

// File: tb/loop_index_node_tb_top.sv
module loop_index_node_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [7:0]  cfg_gap = 8'd0;
  logic        cfg_start_var = 1'b0, cfg_end_var = 1'b0, cfg_incr_var = 1'b0;
  logic [15:0] cfg_start_k = 16'd0, cfg_end_k = 16'd0, cfg_incr_k = 16'd0;
  logic        loop_start = 1'b0, loop_next = 1'b0;
  logic [15:0] start_in_data = 16'd0, end_in_data = 16'd0, incr_in_data = 16'd0;
  logic        start_in_ee = 1'b0, end_in_ee = 1'b0, incr_in_ee = 1'b0;
  logic [15:0] idx_data, exit_data;
  logic        idx_ee, exit_ee;

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  loop_index_node dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_gap(cfg_gap),
    .cfg_start_var(cfg_start_var), .cfg_end_var(cfg_end_var), .cfg_incr_var(cfg_incr_var),
    .cfg_start_k(cfg_start_k), .cfg_end_k(cfg_end_k), .cfg_incr_k(cfg_incr_k),
    .loop_start(loop_start), .loop_next(loop_next),
    .start_in_data(start_in_data), .start_in_ee(start_in_ee),
    .end_in_data(end_in_data), .end_in_ee(end_in_ee),
    .incr_in_data(incr_in_data), .incr_in_ee(incr_in_ee),
    .idx_data(idx_data), .idx_ee(idx_ee), .exit_data(exit_data), .exit_ee(exit_ee)
  );

  task automatic chk16(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Behavioural expectation built from the requirements
  logic [15:0] m_idx, m_xd, m_hs, m_he, m_hi, vs, ve, vi;
  logic        m_ie, m_xe, m_run, fire;
  logic [16:0] cval;
  logic [31:0] m_since;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_xd = 0; m_hs = 0; m_he = 0; m_hi = 0;
      m_ie = 0; m_xe = 0; m_run = 0; m_since = 0;
    end else begin
      vs = cfg_start_var ? (start_in_ee ? start_in_data : m_hs) : cfg_start_k;
      ve = cfg_end_var   ? (end_in_ee   ? end_in_data   : m_he) : cfg_end_k;
      vi = cfg_incr_var  ? (incr_in_ee  ? incr_in_data  : m_hi) : cfg_incr_k;
      if (start_in_ee) m_hs = start_in_data;
      if (end_in_ee)   m_he = end_in_data;
      if (incr_in_ee)  m_hi = incr_in_data;
      fire = loop_start ||
             (m_run && (cfg_mode ? (m_since == {24'd0, cfg_gap}) : loop_next));
      m_ie = 0; m_xe = 0;
      if (fire) begin
        m_since = 0;
        cval = loop_start ? {1'b0, vs} : ({1'b0, m_idx} + {1'b0, vi});
        if (cval >= {1'b0, ve}) begin
          m_xe = 1; m_xd = cval[15:0]; m_run = 0;
        end else begin
          m_ie = 1; m_idx = cval[15:0]; m_run = 1;
        end
      end else if (m_since != 32'hFFFF_FFFF) begin
        m_since = m_since + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk1 ("R3 idx_ee vs model", idx_ee, m_ie);
      chk16("R3 idx_data vs model", idx_data, m_idx);
      chk1 ("R4 exit_ee vs model", exit_ee, m_xe);
      chk16("R4 exit_data vs model", exit_data, m_xd);
    end
  end

  // one cycle with the given pulses; returns at the next falling edge
  task automatic pulse(input logic s, input logic n);
    loop_start = s; loop_next = n;
    @(negedge clk);
    loop_start = 1'b0; loop_next = 1'b0;
  endtask

  task automatic set_cfg(input logic md, input logic [7:0] gp,
                         input logic [15:0] s, input logic [15:0] e, input logic [15:0] i);
    cfg_mode = md; cfg_gap = gp;
    cfg_start_var = 0; cfg_end_var = 0; cfg_incr_var = 0;
    cfg_start_k = s; cfg_end_k = e; cfg_incr_k = i;
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk1 ("R1 idx_ee in reset", idx_ee, 1'b0);
    chk1 ("R1 exit_ee in reset", exit_ee, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;
    chk16("R1 idx_data after reset", idx_data, 16'd0);
    chk16("R1 exit_data after reset", exit_data, 16'd0);

    // R5: step before any start
    pulse(0, 1);
    chk1("R5 no idx before start", idx_ee, 1'b0);

    // stepped loop 3,5 then exit at 7
    set_cfg(0, 8'd0, 16'd3, 16'd6, 16'd2);
    pulse(1, 0);
    chk1 ("R2 first pulse", idx_ee, 1'b1);
    chk16("R2 first value", idx_data, 16'd3);
    pulse(0, 0);
    chk1 ("R10 no pulse idle", idx_ee, 1'b0);
    chk16("R10 value held", idx_data, 16'd3);
    pulse(0, 1);
    chk16("R3 stepped value", idx_data, 16'd5);
    chk1 ("R3 stepped pulse", idx_ee, 1'b1);
    pulse(0, 1);
    chk1 ("R4 exit pulse", exit_ee, 1'b1);
    chk1 ("R4 no idx at exit", idx_ee, 1'b0);
    chk16("R4 exit value", exit_data, 16'd7);
    pulse(0, 1);
    chk1("R5 quiet after exit idx", idx_ee, 1'b0);
    chk1("R5 quiet after exit exit", exit_ee, 1'b0);

    // R4: first value already at bound
    set_cfg(0, 8'd0, 16'd9, 16'd9, 16'd1);
    pulse(1, 0);
    chk1("R4 immediate exit", exit_ee, 1'b1);
    chk1("R4 immediate no idx", idx_ee, 1'b0);

    // R4: overflow past 16 bits
    set_cfg(0, 8'd0, 16'd65530, 16'd65535, 16'd10);
    pulse(1, 0);
    pulse(0, 1);
    chk1 ("R4 overflow exit", exit_ee, 1'b1);
    chk16("R4 overflow exit value", exit_data, 16'd4);

    // R6: bound from port earlier, first value bypassed in same cycle
    set_cfg(0, 8'd0, 16'd0, 16'd0, 16'd1);
    cfg_end_var = 1; end_in_data = 16'd10; end_in_ee = 1;
    pulse(0, 0);
    end_in_ee = 0; end_in_data = 16'd500;
    cfg_start_var = 1; start_in_data = 16'd8; start_in_ee = 1;
    pulse(1, 0);
    start_in_ee = 0;
    chk16("R6 variable first value", idx_data, 16'd8);
    pulse(0, 1);
    chk16("R6 step under held bound", idx_data, 16'd9);
    pulse(0, 1);
    chk1("R6 exit at held bound", exit_ee, 1'b1);

    // R9: restart beats a simultaneous step
    set_cfg(0, 8'd0, 16'd0, 16'd100, 16'd1);
    pulse(1, 0);
    pulse(0, 1);
    pulse(0, 1);
    chk16("R9 before restart", idx_data, 16'd2);
    pulse(1, 1);
    chk16("R9 restart value", idx_data, 16'd0);
    chk1 ("R9 restart pulse", idx_ee, 1'b1);

    // R7: self-paced, gap 2, step pulses ignored
    set_cfg(1, 8'd2, 16'd0, 16'd3, 16'd1);
    pulse(1, 0);
    chk1("R7 gap2 sample0", idx_ee, 1'b1);
    for (int i = 1; i <= 9; i++) begin
      loop_next = 1'b1;
      @(negedge clk);
      chk1("R7 gap2 idx spacing", idx_ee, ((i % 3) == 0) && (i < 9));
      chk1("R7 gap2 exit timing", exit_ee, i == 9);
    end
    loop_next = 1'b0;

    // R8: self-paced, gap 0
    set_cfg(1, 8'd0, 16'd0, 16'd4, 16'd1);
    pulse(1, 0);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk1 ("R8 every-cycle pulse", idx_ee, i < 4);
      if (i < 4) chk16("R8 every-cycle value", idx_data, i[15:0]);
    end
    chk1("R8 exit after run", exit_ee, 1'b1);

    // constrained random: new config only together with a start
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 30) == 0) begin
        cfg_mode = 1'($urandom % 2);
        cfg_gap = 8'($urandom % 4);
        cfg_start_var = 1'($urandom % 2);
        cfg_end_var = 1'($urandom % 2);
        cfg_incr_var = 1'($urandom % 2);
        cfg_start_k = 16'($urandom % 20);
        cfg_end_k = 16'($urandom % 40);
        cfg_incr_k = 16'($urandom % 6);
        loop_start = 1'b1;
      end else begin
        loop_start = (($urandom % 80) == 0);
      end
      loop_next = (($urandom % 3) == 0);
      start_in_ee = (($urandom % 10) == 0); start_in_data = 16'($urandom % 20);
      end_in_ee = (($urandom % 10) == 0);   end_in_data = 16'($urandom % 40);
      incr_in_ee = (($urandom % 10) == 0);  incr_in_data = 16'($urandom % 6);
      @(negedge clk);
    end
    loop_start = 0; loop_next = 0;
    start_in_ee = 0; end_in_ee = 0; incr_in_ee = 0;
    @(negedge clk);
    chk_on = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule